// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Pipeline Register Stage

This block is one register stage of a handshaked dual-rail pipeline. Each bit is carried on a pair of wires: the true wire high means one, the false wire high means zero, and both low is the empty (spacer) state. Every wire passes through its own state-holding agreement cell (a Muller C-element). The cell's second input is the inverted acknowledge from the next stage. A new code word therefore enters only while the next stage is not acknowledging. A spacer enters only while it is.

A completion detector watches the stage outputs. It reports upstream when every output pair carries data, and it withdraws that report only when every pair has returned to spacer. Stages chain directly: the `up_ack` of one stage feeds the `dn_ack` of the stage before it. The agreement cells are modelled as state cells that update on a sampling clock, so the model can run on a synchronous fabric. The transfer itself needs no clock enable, because completion detection takes its place.

Top module: `rtz_stage`

## Requirements
- R1: While reset is asserted, every output rail is 0 (all pairs spacer) and `up_ack` is 0.
- R2: Pair encoding: {true,false} = 2'b10 is one, 2'b01 is zero, 2'b00 is spacer and 2'b11 is never produced. A transferred word appears as `out_t` equal to the word and `out_f` equal to its complement.
- R3: With `dn_ack` low, a valid word on the inputs appears on the outputs after one sampling clock edge.
- R4: `up_ack` rises only after every output pair is valid. While any pair is still spacer, it stays low.
- R5: `up_ack` falls only after every output pair is spacer. While any pair still holds data, it stays high.
- R6: While `dn_ack` is low, a valid output word is held unchanged, even after the inputs return to spacer.
- R7: While `dn_ack` is high, a new valid word on the inputs is ignored: the outputs stay spacer.
- R8: Under random sender and receiver delays, every word reaches the output once, in the order it was sent, with nothing lost or duplicated.
- R9: The parameters are checked at elaboration: WIDTH must be at least 1 and GROUP at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the state-holding cells |
| rst_n | input | 1 | Active-low reset; forces spacer and a low acknowledge |
| in_t | input | WIDTH | True rails from the previous stage |
| in_f | input | WIDTH | False rails from the previous stage |
| dn_ack | input | 1 | Acknowledge from the next stage |
| out_t | output | WIDTH | True rails toward the next stage |
| out_f | output | WIDTH | False rails toward the next stage |
| up_ack | output | 1 | Completion, sent upstream as the acknowledge |

## Verification
The bench checks the completion hysteresis with partial words. If one pair is left spacer, a detector that fires on any valid pair would raise the acknowledge early. If one pair is kept valid while the rest clear, a detector that clears on any spacer pair would drop it early. It also drives a new word while the downstream acknowledge is still high; a stage whose gating ignored `dn_ack` would let that word overwrite the spacer. Finally, it returns the inputs to spacer before the receiver acknowledges; a stage without hold behaviour would lose the word at that point. A random-delay stream then exposes lost, duplicated or reordered words.

// File: rtl/rtz_pkg.sv
package rtz_pkg;
   // Code on one dual-rail pair, written {true, false}
   typedef enum logic [1:0] {
      RAIL_SPACER = 2'b00,
      RAIL_ZERO   = 2'b01,
      RAIL_ONE    = 2'b10,
      RAIL_BAD    = 2'b11
   } rail_pair_e;
endpackage

// File: rtl/rtz_celem.sv
module rtz_celem #(
   parameter int N_IN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] c_in,
   output logic            c_out
);
   if (N_IN < 1) begin : g_bad_n
      $error("rtz_celem: N_IN must be at least 1");
   end

   // Agreement cell: follows the inputs when they all match, otherwise keeps state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          c_out <= 1'b0;
      else if (&c_in)      c_out <= 1'b1;
      else if (~|c_in)     c_out <= 1'b0;
   end

   AST_CEL_RISE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c_out) |-> $past(&c_in));   // R4
   AST_CEL_FALL_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(c_out) |-> $past(~|c_in));  // R5
endmodule

// File: rtl/rtz_done.sv
module rtz_done
   import rtz_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int GROUP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rail_t,
   input  logic [WIDTH-1:0] rail_f,
   output logic             done
);
   localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
   localparam int PADW = NGRP * GROUP;

   logic [WIDTH-1:0] pair_ok;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pair
      assign pair_ok[i] = (rail_pair_e'({rail_t[i], rail_f[i]}) != RAIL_SPACER);
   end

   if (WIDTH <= GROUP) begin : g_flat
      rtz_celem #(.N_IN(WIDTH)) u_root (
         .clk   (clk),
         .rst_n (rst_n),
         .c_in  (pair_ok),
         .c_out (done)
      );
   end else begin : g_tree
      logic [PADW-1:0] padded;
      logic [NGRP-1:0] grp_done;

      // Unused slots of the last group repeat its top pair, so hysteresis is kept
      for (genvar j = 0; j < PADW; j++) begin : g_pad
         if (j < WIDTH) begin : g_real
            assign padded[j] = pair_ok[j];
         end else begin : g_fill
            assign padded[j] = pair_ok[WIDTH-1];
         end
      end

      for (genvar g = 0; g < NGRP; g++) begin : g_leaf
         rtz_celem #(.N_IN(GROUP)) u_leaf (
            .clk   (clk),
            .rst_n (rst_n),
            .c_in  (padded[g*GROUP +: GROUP]),
            .c_out (grp_done[g])
         );
      end

      rtz_celem #(.N_IN(NGRP)) u_root (
         .clk   (clk),
         .rst_n (rst_n),
         .c_in  (grp_done),
         .c_out (done)
      );
   end
endmodule

// File: rtl/rtz_stage.sv
module rtz_stage #(
   parameter int WIDTH = 8,
   parameter int GROUP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] in_t,
   input  logic [WIDTH-1:0] in_f,
   input  logic             dn_ack,
   output logic [WIDTH-1:0] out_t,
   output logic [WIDTH-1:0] out_f,
   output logic             up_ack
);
   if (WIDTH < 1) begin : g_bad_width
      $error("rtz_stage: WIDTH must be at least 1");   // R9
   end
   if (GROUP < 2) begin : g_bad_group
      $error("rtz_stage: GROUP must be at least 2");   // R9
   end

   logic take_en;
   assign take_en = ~dn_ack;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rtz_celem #(.N_IN(2)) u_t (
         .clk   (clk),
         .rst_n (rst_n),
         .c_in  ({in_t[i], take_en}),
         .c_out (out_t[i])
      );
      rtz_celem #(.N_IN(2)) u_f (
         .clk   (clk),
         .rst_n (rst_n),
         .c_in  ({in_f[i], take_en}),
         .c_out (out_f[i])
      );
   end

   rtz_done #(.WIDTH(WIDTH), .GROUP(GROUP)) u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .rail_t (out_t),
      .rail_f (out_f),
      .done   (up_ack)
   );

   // Per-pair occupancy of the outputs, used by the checks below
   logic [WIDTH-1:0] pair_live;
   assign pair_live = out_t | out_f;

   AST_NO_BAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_t & out_f) == '0);   // R2
   AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(dn_ack) && ($past(pair_live) == {WIDTH{1'b1}}))
         |-> ($stable(out_t) && $stable(out_f)));   // R6
   AST_BLOCK_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dn_ack) && ($past(pair_live) == '0)) |-> (pair_live == '0));   // R7
endmodule

// File: tb/sim_rtz_stage.sv
module sim_rtz_stage;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int NW = 12;
   localparam logic [W-1:0] WORDS [NW] = '{
      8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80,
      8'h3C, 8'hC3, 8'h77, 8'h00, 8'h96, 8'hFE };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] in_t = '0, in_f = '0;
   logic dn_ack = 1'b0;
   logic [W-1:0] out_t, out_f;
   logic up_ack;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtz_stage #(.WIDTH(W), .GROUP(4)) u0 (
      .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .dn_ack(dn_ack),
      .out_t(out_t), .out_f(out_f), .up_ack(up_ack));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [W-1:0] w);
      in_t = w;
      in_f = ~w;
   endtask

   task automatic space();
      in_t = '0;
      in_f = '0;
   endtask

   task automatic rand_wait();
      repeat ($urandom_range(0, 4)) @(negedge clk);
   endtask

   task automatic check_word(input string req, input logic [W-1:0] w);
      check(out_t == w && out_f == ~w, req, "output word",
            {16'h0, out_t, out_f}, {16'h0, w, ~w});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      // R1: reset state
      tick(3);
      check(out_t == '0 && out_f == '0, "R1", "rails in reset", {16'h0, out_t, out_f}, 0);
      check(up_ack == 1'b0, "R1", "ack in reset", {31'h0, up_ack}, 0);
      rst_n = 1'b1;
      tick(2);

      // R2 and R3: word visible after one edge, encoding exact
      send(8'h01);
      tick(1);
      check(out_t == 8'h01, "R2", "true rails", {24'h0, out_t}, 32'h01);
      check(out_f == 8'hFE, "R2", "false rails", {24'h0, out_f}, 32'hFE);
      tick(5);
      check(up_ack == 1'b1, "R4", "ack after full word", {31'h0, up_ack}, 1);

      // R6: inputs to spacer, receiver still idle
      space();
      tick(4);
      check_word("R6", 8'h01);
      check(up_ack == 1'b1, "R6", "ack while held", {31'h0, up_ack}, 1);

      // R5: pair 0 kept valid, others clear
      in_f[0] = 1'b0; in_t[0] = 1'b1;
      dn_ack = 1'b1;
      tick(5);
      check(out_t == 8'h01 && out_f == 8'h00, "R5", "partial spacer rails",
            {16'h0, out_t, out_f}, 32'h0100);
      check(up_ack == 1'b1, "R5", "ack held on partial spacer", {31'h0, up_ack}, 1);
      space();
      tick(6);
      check(out_t == '0 && out_f == '0, "R5", "full spacer rails", {16'h0, out_t, out_f}, 0);
      check(up_ack == 1'b0, "R5", "ack drop on full spacer", {31'h0, up_ack}, 0);

      // R7: new word while dn_ack still high
      send(8'h3C);
      tick(4);
      check(out_t == '0 && out_f == '0, "R7", "blocked word", {16'h0, out_t, out_f}, 0);
      check(up_ack == 1'b0, "R7", "ack stays low", {31'h0, up_ack}, 0);
      dn_ack = 1'b0;
      tick(1);
      check_word("R3", 8'h3C);
      tick(5);
      space();
      dn_ack = 1'b1;
      tick(6);
      dn_ack = 1'b0;
      tick(2);

      // R4: pair 7 left spacer
      send(8'h55);
      in_t[7] = 1'b0; in_f[7] = 1'b0;
      tick(6);
      check(up_ack == 1'b0, "R4", "ack low on partial word", {31'h0, up_ack}, 0);
      in_f[7] = 1'b1;
      tick(6);
      check(up_ack == 1'b1, "R4", "ack after completion", {31'h0, up_ack}, 1);
      check_word("R3", 8'h55);
      space();
      dn_ack = 1'b1;
      tick(6);
      dn_ack = 1'b0;
      tick(2);
      check(up_ack == 1'b0 && out_t == '0 && out_f == '0, "R8", "idle before stream",
            {15'h0, up_ack, out_t, out_f}, 0);

      // R8: table walked by random-delay sender and receiver
      fork
         begin : sender
            for (int k = 0; k < NW; k++) begin
               @(negedge clk);
               while (up_ack) @(negedge clk);
               rand_wait();
               send(WORDS[k]);
               @(negedge clk);
               while (!up_ack) @(negedge clk);
               rand_wait();
               space();
            end
         end
         begin : receiver
            for (int k = 0; k < NW; k++) begin
               @(negedge clk);
               while ((out_t | out_f) != {W{1'b1}}) @(negedge clk);
               rand_wait();
               check_word("R8", WORDS[k]);
               dn_ack = 1'b1;
               @(negedge clk);
               while ((out_t | out_f) != '0) @(negedge clk);
               rand_wait();
               dn_ack = 1'b0;
            end
         end
      join
      tick(12);
      check((out_t | out_f) == '0 && up_ack == 1'b0, "R8", "no extra word after stream",
            {15'h0, up_ack, out_t, out_f}, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule